// File: doc/BRIEF.md
# Transmit Timestamp Capture Unit

This block sits beside a MAC transmit path and records the 64-bit system time at the moment an outgoing frame's start frame delimiter appears on the MII transmit nibble stream. Software decides frame by frame whether a timestamp is wanted. A request flag and a descriptor index are presented with a one-cycle frame-start strobe before the frame goes out. The block never looks at frame contents to decide; only that flag does.

When a flagged frame's delimiter is seen, the captured time is split into two 32-bit words laid out for the frame's own descriptor. The upper half is the word that lands in descriptor word 6 and the lower half the word for descriptor word 7. A one-cycle valid strobe and the frame's descriptor index go with the two words, so the write-back lands in the descriptor that asked for it.

Top module: `txTsCapture`

## Requirements
- R1: After reset `tsValid` is 0 and `tsWordHi`, `tsWordLo` and `tsDescIdx` are all 0.
- R2: The delimiter is one or more nibbles 0x5 followed by the nibble 0xD, all sampled with `txEn` high. For a flagged frame, `tsValid` is high in the cycle after the clock edge that samples the 0xD nibble. The words then hold the `sysTime` value sampled at that same edge.
- R3: `tsWordHi` carries `sysTime` bits 63..32, which is descriptor word 6. `tsWordLo` carries bits 31..0, which is descriptor word 7.
- R4: `tsDescIdx` equals the `descIdx` sampled with the most recent `frameStart` strobe.
- R5: A frame whose `tsReq` was 0 at `frameStart` gives no `tsValid`, and the three output words keep their previous values.
- R6: At most one capture is made per frame. Further 0x5,0xD pairs in the frame body are ignored. Capture re-arms when `txEn` is low for a cycle.
- R7: A 0xD nibble not directly preceded by a 0x5 nibble with `txEn` high is not a delimiter. A 0xD nibble sampled with `txEn` low is not a delimiter either.
- R8: `tsValid` is high for exactly one cycle per capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe before a frame; samples `tsReq` and `descIdx` |
| tsReq | input | 1 | Per-frame timestamp request flag from the descriptor |
| descIdx | input | IDX_W | Index of the frame's descriptor |
| txEn | input | 1 | MII transmit enable |
| txData | input | NIB_W | MII transmit nibble |
| sysTime | input | TIME_W | Current system time |
| tsWordHi | output | TIME_W/2 | Upper timestamp half (descriptor word 6) |
| tsWordLo | output | TIME_W/2 | Lower timestamp half (descriptor word 7) |
| tsDescIdx | output | IDX_W | Descriptor index for the write-back |
| tsValid | output | 1 | One-cycle write strobe |

## Verification
The main function is tried with several frame shapes:
- **Flagged frames with short and long preambles** show that the delimiter is found after any run of 0x5 nibbles and that the time comes from the exact delimiter edge. A time base that carries across the low word during the run separates the two halves.
- **Frames with unflagged requests** are followed by a check of the held outputs. This tells "no capture" apart from "capture with stale data".
- **Frame bodies full of 0x5,0xD pairs** tell one-shot capture apart from repeated triggering.
- **A 0xD with no preamble, and a 0xD after `txEn` drops**, tell true delimiter detection apart from simple nibble matching.

// File: rtl/txTsCapture_pkg.sv
package txTsCapture_pkg;
  localparam logic [3:0] PRE_NIB = 4'h5;
  localparam logic [3:0] SFD_NIB = 4'hD;

  typedef struct packed {
    logic loadIdx;   // latch descriptor index at frame start
    logic capture;   // latch time and raise the write strobe
  } ctrlStrobes_t;
endpackage

// File: rtl/txTsCtrl.sv
module txTsCtrl
  import txTsCapture_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             tsReq,
  input  logic             txEn,
  input  logic [NIB_W-1:0] txData,
  output ctrlStrobes_t     strobes
);
  logic prePrev;
  logic armed;
  logic reqPend;
  logic sfdHit;

  // delimiter: current nibble 0xD, previous nibble 0x5, both with txEn high
  assign sfdHit = txEn && (txData == NIB_W'(SFD_NIB)) && prePrev && armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prePrev <= 1'b0;
      armed   <= 1'b1;
      reqPend <= 1'b0;
    end else begin
      prePrev <= txEn && (txData == NIB_W'(PRE_NIB));
      if (!txEn)       armed <= 1'b1;
      else if (sfdHit) armed <= 1'b0;
      if (frameStart)  reqPend <= tsReq;
    end
  end

  always_comb begin
    strobes.loadIdx = frameStart;
    strobes.capture = sfdHit && reqPend;
  end
endmodule

// File: rtl/txTsDatapath.sv
module txTsDatapath
  import txTsCapture_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int IDX_W  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [IDX_W-1:0]    descIdx,
  input  logic [TIME_W-1:0]   sysTime,
  output logic [TIME_W/2-1:0] tsWordHi,
  output logic [TIME_W/2-1:0] tsWordLo,
  output logic [IDX_W-1:0]    tsDescIdx,
  output logic                tsValid
);
  localparam int HALF = TIME_W / 2;

  logic [IDX_W-1:0] idxHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxHeld   <= '0;
      tsWordHi  <= '0;
      tsWordLo  <= '0;
      tsDescIdx <= '0;
      tsValid   <= 1'b0;
    end else begin
      if (strobes.loadIdx) idxHeld <= descIdx;
      tsValid <= strobes.capture;
      if (strobes.capture) begin
        tsWordHi  <= sysTime[TIME_W-1:HALF];
        tsWordLo  <= sysTime[HALF-1:0];
        tsDescIdx <= idxHeld;
      end
    end
  end
endmodule

// File: rtl/txTsCapture.sv
module txTsCapture
  import txTsCapture_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int IDX_W  = 6,
  parameter int NIB_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic                tsReq,
  input  logic [IDX_W-1:0]    descIdx,
  input  logic                txEn,
  input  logic [NIB_W-1:0]    txData,
  input  logic [TIME_W-1:0]   sysTime,
  output logic [TIME_W/2-1:0] tsWordHi,
  output logic [TIME_W/2-1:0] tsWordLo,
  output logic [IDX_W-1:0]    tsDescIdx,
  output logic                tsValid
);
  ctrlStrobes_t strobes;

  txTsCtrl #(.NIB_W(NIB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .tsReq(tsReq),
    .txEn(txEn), .txData(txData), .strobes(strobes)
  );

  txTsDatapath #(.TIME_W(TIME_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .descIdx(descIdx),
    .sysTime(sysTime), .tsWordHi(tsWordHi), .tsWordLo(tsWordLo),
    .tsDescIdx(tsDescIdx), .tsValid(tsValid)
  );
endmodule

// File: rtl/txTsCapture_chk.sv
module txTsCapture_chk #(
  parameter int TIME_W = 64,
  parameter int IDX_W  = 6,
  parameter int NIB_W  = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                txEn,
  input logic [NIB_W-1:0]    txData,
  input logic [TIME_W-1:0]   sysTime,
  input logic [TIME_W/2-1:0] tsWordHi,
  input logic [TIME_W/2-1:0] tsWordLo,
  input logic [IDX_W-1:0]    tsDescIdx,
  input logic                tsValid
);
  localparam int HALF = TIME_W / 2;

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    tsValid |=> !tsValid);

  assert_hold_unflagged_R5: assert property (@(posedge clk) disable iff (!rstN)
    !tsValid |-> ($stable(tsWordHi) && $stable(tsWordLo) && $stable(tsDescIdx)));

  assert_sfd_trigger_R7: assert property (@(posedge clk) disable iff (!rstN)
    tsValid |-> ($past(txEn) && ($past(txData) == NIB_W'(4'hD))));

  assert_time_split_R3: assert property (@(posedge clk) disable iff (!rstN)
    tsValid |-> ((tsWordLo == $past(sysTime[HALF-1:0])) &&
                 (tsWordHi == $past(sysTime[TIME_W-1:HALF]))));
endmodule

bind txTsCapture txTsCapture_chk #(.TIME_W(TIME_W), .IDX_W(IDX_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rstN(rstN), .txEn(txEn), .txData(txData), .sysTime(sysTime),
  .tsWordHi(tsWordHi), .tsWordLo(tsWordLo), .tsDescIdx(tsDescIdx), .tsValid(tsValid)
);

// File: tb/txTsCapture_tb.sv
`timescale 1ns/1ps
module txTsCapture_tb;
  localparam int TIME_W = 64;
  localparam int IDX_W  = 6;
  localparam int NIB_W  = 4;
  localparam int HALF   = TIME_W / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, tsReq = 1'b0, txEn = 1'b0;
  logic [IDX_W-1:0] descIdx = '0;
  logic [NIB_W-1:0] txData = '0;
  logic [TIME_W-1:0] sysTime;
  logic [HALF-1:0] tsWordHi, tsWordLo;
  logic [IDX_W-1:0] tsDescIdx;
  logic tsValid;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [TIME_W+IDX_W-1:0] expQ[$];
  logic [TIME_W+IDX_W-1:0] lastOut = '0;
  logic prevValid = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  // time base crosses a low-word carry during the run
  assign sysTime = 64'hA5A5_0001_FFFF_FF80 + 64'(cyc) * 3;

  txTsCapture #(.TIME_W(TIME_W), .IDX_W(IDX_W), .NIB_W(NIB_W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare on every strobe
  always @(negedge clk) if (rstN && !finished) begin
    if (tsValid) begin
      check(!prevValid, "R8 pulse width", 128'(prevValid), 128'(0));
      if (expQ.size() == 0) check(0, "R5/R6/R7 unexpected capture", 128'(tsWordLo), 128'(0));
      else begin
        logic [TIME_W+IDX_W-1:0] e;
        e = expQ.pop_front();
        check(tsWordHi == e[TIME_W+IDX_W-1:IDX_W+HALF], "R3 word6 upper half", 128'(tsWordHi), 128'(e[TIME_W+IDX_W-1:IDX_W+HALF]));
        check(tsWordLo == e[IDX_W+HALF-1:IDX_W], "R2 word7 lower half at SFD", 128'(tsWordLo), 128'(e[IDX_W+HALF-1:IDX_W]));
        check(tsDescIdx == e[IDX_W-1:0], "R4 descriptor index", 128'(tsDescIdx), 128'(e[IDX_W-1:0]));
      end
      lastOut = {tsWordHi, tsWordLo, tsDescIdx};
    end
    prevValid = tsValid;
  end

  // mode 0: normal data, 1: body full of 5,D pairs, 2: no preamble before D
  task automatic sendFrame(input bit req, input logic [IDX_W-1:0] idx, input int nPre, input int mode);
    @(negedge clk); frameStart = 1; tsReq = req; descIdx = idx;
    @(negedge clk); frameStart = 0; tsReq = 0; descIdx = '0;
    txEn = 1;
    if (mode == 2) begin txData = 4'h1; @(negedge clk); end
    for (int i = 0; i < nPre; i++) begin txData = 4'h5; @(negedge clk); end
    txData = 4'hD;
    if (req && mode != 2) expQ.push_back({sysTime, idx});
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      txData = (mode == 1) ? ((i % 2 == 0) ? 4'h5 : 4'hD) : 4'(i + 6);
      if (mode != 1 && txData == 4'hD) txData = 4'h3;
      if (mode != 1 && txData == 4'h5) txData = 4'h3;
    end
    @(negedge clk); txEn = 0; txData = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkHeld(input string req);
    check({tsWordHi, tsWordLo, tsDescIdx} == lastOut, req, 128'({tsWordHi, tsWordLo, tsDescIdx}), 128'(lastOut));
    check(!tsValid, req, 128'(tsValid), 128'(0));
  endtask

  task automatic finish_run();
    check(expQ.size() == 0, "R2 all captures seen", 128'(expQ.size()), 128'(0));
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tsValid == 0 && tsWordHi == 0 && tsWordLo == 0 && tsDescIdx == 0, "R1 reset state",
          128'({tsValid, tsWordHi, tsWordLo, tsDescIdx}), 128'(0));
    rstN = 1;
    repeat (2) @(negedge clk);
    sendFrame(1, 6'd5, 15, 0);               // R2 long preamble
    sendFrame(1, 6'd9, 1, 0);                // R2 single-nibble preamble, R6 re-arm
    sendFrame(0, 6'd33, 7, 0);               // R5 unflagged
    checkHeld("R5 unflagged frame held outputs");
    sendFrame(1, 6'd63, 7, 1);               // R6 body of 5,D pairs
    checkHeld("R6 single capture per frame");
    sendFrame(1, 6'd17, 0, 2);               // R7 D without preamble
    checkHeld("R7 D without preamble ignored");
    // R7: 5 with txEn high, then D with txEn low
    @(negedge clk); frameStart = 1; tsReq = 1; descIdx = 6'd44;
    @(negedge clk); frameStart = 0; txEn = 1; txData = 4'h5;
    @(negedge clk); txEn = 0; txData = 4'hD;
    @(negedge clk); txData = '0;
    repeat (3) @(negedge clk);
    checkHeld("R7 D with txEn low ignored");
    sendFrame(1, 6'd21, 3, 0);               // R4 new index after R7 cases
    sendFrame(0, 6'd2, 4, 1);                // R5 unflagged with pairs
    checkHeld("R5 unflagged pairs held outputs");
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "R1 watchdog", 128'(cyc), 128'(0));
      finish_run();
    end
  end
endmodule